// File: doc/BRIEF.md
# Direct-Page Word Increment/Decrement Sequencer

This block carries out a 16-bit increment or decrement of a word kept in memory as two neighbouring bytes of a 256-byte direct page, low byte first. It starts when a one-cycle `start` strobe arrives with a recognised opcode. It then drives the byte bus for five cycles. First it fetches the one-byte page offset from the instruction stream. Next it reads the low byte and adjusts it, then writes the low byte back. After that it reads the high byte and writes the high byte back with the carry or borrow folded in.

The negative and zero flags come from the whole 16-bit result. They are presented together with a one-cycle `done` strobe, which marks the high-byte write. The enclosing processor uses those flags to update its status word. The sequencer has no other effect on the carry, the overflow or any register.

Top module: `dp_word_incdec`

## Requirements
- R1: After reset the block is idle: `opFetch`, `busRead`, `busWrite` and `done` are all low, and they stay low until a recognised opcode is started.
- R2: Opcode 0x3A adds one to the little-endian word and opcode 0x1A subtracts one. The low byte sits at the offset and the high byte at the offset plus one. Any other opcode presented with `start` is ignored and causes no bus activity.
- R3: The cycle after `start` is taken, the block spends five cycles in this fixed order: offset fetch (`opFetch`), read at the offset, write at the offset, read at the offset plus one, write at the offset plus one. In each of these cycles exactly one of `opFetch`, `busRead` or `busWrite` is high.
- R4: The adjusted low byte is written in the cycle immediately before the high byte is read.
- R5: When an increment carries out of the low byte (low byte 0xFF), or a decrement borrows from it (low byte 0x00), the high byte written is one more or one less than the high byte read. In all other cases the high byte is written back unchanged.
- R6: During the `done` cycle, `flagN` equals bit 15 of the result. `flagZ` is high only if all 16 result bits are zero.
- R7: The high-byte address is the offset plus one taken modulo 256, so offset 0xFF pairs with 0x00.
- R8: `done` is high for exactly one cycle, and that cycle is the high-byte write. A `start` that arrives while an operation is running is ignored.
- R9: Incrementing 0xFFFF gives 0x0000 with `flagZ` set. Decrementing 0x0000 gives 0xFFFF with `flagN` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when idle and the opcode is recognised |
| opcode | input | 8 | Operation code, sampled with `start` |
| busRdata | input | 8 | Read data: instruction byte during `opFetch`, otherwise memory data |
| opFetch | output | 1 | Requests the next instruction-stream byte (the offset) |
| busRead | output | 1 | Direct-page read strobe |
| busWrite | output | 1 | Direct-page write strobe |
| busAddr | output | 8 | Direct-page address for a read or write |
| busWdata | output | 8 | Write data |
| done | output | 1 | One-cycle completion strobe, shown with the high-byte write |
| flagN | output | 1 | Negative flag of the 16-bit result, valid with `done` |
| flagZ | output | 1 | Zero flag of the 16-bit result, valid with `done` |

## Verification
The assertions check properties of every cycle. At most one bus action is active at a time, and a fetch is always followed by a read. Each low-byte write is followed by a read at the next address modulo 256. `done` is a single pulse that only appears during a write, and the two flags agree with the byte written now and the byte written two cycles earlier.

Only the bench's scenarios can show that the arithmetic is correct. They sweep every low-byte value across several high bytes and offsets, so every carry and borrow boundary is hit, including the two full-word wraparounds. The scenarios also cover unrecognised opcodes and a `start` that arrives in the middle of an operation.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  localparam int OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_WORD_INC = 8'h3A;
  localparam logic [OPC_W-1:0] OPC_WORD_DEC = 8'h1A;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RDLO, ST_WRLO, ST_RDHI, ST_WRHI
  } dpw_state_t;

  typedef struct packed {
    logic ldDir;   // capture direction at start
    logic isDec;   // direction value to capture
    logic ldOff;   // capture offset from fetch
    logic ldLo;    // capture and adjust low byte
    logic ldHi;    // capture and adjust high byte
    logic selHi;   // address/data select high byte
  } dpw_strobe_t;
endpackage

// File: rtl/dpw_ctrl.sv
module dpw_ctrl
  import dpw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  output dpw_strobe_t       stb,
  output logic              opFetch,
  output logic              busRead,
  output logic              busWrite,
  output logic              done
);
  dpw_state_t state, stateNext;
  logic opcodeOk, takeStart;

  assign opcodeOk  = (opcode == OPC_WORD_INC) || (opcode == OPC_WORD_DEC);
  assign takeStart = (state == ST_IDLE) && start && opcodeOk;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (takeStart) stateNext = ST_FETCH;
      ST_FETCH: stateNext = ST_RDLO;
      ST_RDLO:  stateNext = ST_WRLO;
      ST_WRLO:  stateNext = ST_RDHI;
      ST_RDHI:  stateNext = ST_WRHI;
      ST_WRHI:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.ldDir = takeStart;
    stb.isDec = (opcode == OPC_WORD_DEC);
    stb.ldOff = (state == ST_FETCH);
    stb.ldLo  = (state == ST_RDLO);
    stb.ldHi  = (state == ST_RDHI);
    stb.selHi = (state == ST_RDHI) || (state == ST_WRHI);
  end

  assign opFetch  = (state == ST_FETCH);
  assign busRead  = (state == ST_RDLO) || (state == ST_RDHI);
  assign busWrite = (state == ST_WRLO) || (state == ST_WRHI);
  assign done     = (state == ST_WRHI);
endmodule

// File: rtl/dpw_datapath.sv
module dpw_datapath
  import dpw_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpw_strobe_t       stb,
  input  logic              doneIn,
  input  logic [BYTE_W-1:0] busRdata,
  output logic [BYTE_W-1:0] busAddr,
  output logic [BYTE_W-1:0] busWdata,
  output logic              flagN,
  output logic              flagZ
);
  localparam logic [BYTE_W-1:0] ONE  = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] ZERO = '0;
  localparam logic [BYTE_W-1:0] ONES = '1;

  logic              decMode;
  logic              carryReg;
  logic [BYTE_W-1:0] offReg, loAdj, hiAdj, stepHi;

  // High byte is adjusted by the carry/borrow from the low byte only
  assign stepHi = carryReg ? ONE : ZERO;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decMode  <= 1'b0;
      carryReg <= 1'b0;
      offReg   <= '0;
      loAdj    <= '0;
      hiAdj    <= '0;
    end else begin
      if (stb.ldDir) decMode <= stb.isDec;
      if (stb.ldOff) offReg <= busRdata;
      if (stb.ldLo) begin
        loAdj    <= decMode ? busRdata - ONE : busRdata + ONE;
        carryReg <= decMode ? (busRdata == ZERO) : (busRdata == ONES);
      end
      if (stb.ldHi) hiAdj <= decMode ? busRdata - stepHi : busRdata + stepHi;
    end
  end

  // Offset plus one wraps inside the page through the fixed byte width
  assign busAddr  = stb.selHi ? offReg + ONE : offReg;
  assign busWdata = stb.selHi ? hiAdj : loAdj;
  assign flagN    = doneIn & hiAdj[BYTE_W-1];
  assign flagZ    = doneIn & (hiAdj == ZERO) & (loAdj == ZERO);
endmodule

// File: rtl/dp_word_incdec.sv
module dp_word_incdec
  import dpw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [7:0]  busRdata,
  output logic        opFetch,
  output logic        busRead,
  output logic        busWrite,
  output logic [7:0]  busAddr,
  output logic [7:0]  busWdata,
  output logic        done,
  output logic        flagN,
  output logic        flagZ
);
  dpw_strobe_t stb;
  logic        doneInt;

  dpw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .stb(stb),
    .opFetch(opFetch), .busRead(busRead), .busWrite(busWrite), .done(doneInt)
  );

  dpw_datapath #(.BYTE_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .doneIn(doneInt), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .flagN(flagN), .flagZ(flagZ)
  );

  assign done = doneInt;
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker (
  input logic       clk,
  input logic       rstN,
  input logic       opFetch,
  input logic       busRead,
  input logic       busWrite,
  input logic [7:0] busAddr,
  input logic [7:0] busWdata,
  input logic       done,
  input logic       flagN,
  input logic       flagZ
);
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones({opFetch, busRead, busWrite}) <= 1);

  p_fetch_then_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    opFetch |=> busRead);

  // R4 / R7: low write is followed at once by the high read at offset+1 mod 256
  p_low_write_then_high_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !done) |=> (busRead && busAddr == $past(busAddr) + 8'd1));

  p_done_on_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busWrite);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_nflag_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagN == busWdata[7]));

  p_zflag_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flagZ == ((busWdata == 8'h00) && ($past(busWdata, 2) == 8'h00))));
endmodule

bind dp_word_incdec dpw_checker u_dpw_checker (
  .clk(clk), .rstN(rstN), .opFetch(opFetch), .busRead(busRead),
  .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .done(done), .flagN(flagN), .flagZ(flagZ)
);

// File: tb/dp_word_incdec_bench.sv
module dp_word_incdec_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] busRdata;
  logic       opFetch, busRead, busWrite, done, flagN, flagZ;
  logic [7:0] busAddr, busWdata;

  logic [7:0] mem [256];
  logic [7:0] progByte = 8'h00;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  dp_word_incdec u_dp_word_incdec (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .busRdata(busRdata),
    .opFetch(opFetch), .busRead(busRead), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .done(done), .flagN(flagN), .flagZ(flagZ)
  );

  always_comb busRdata = opFetch ? progByte : mem[busAddr];
  always @(posedge clk) if (busWrite) mem[busAddr] <= busWdata;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full operation; midStart re-asserts start during the run (R8)
  task automatic runOne(input logic [7:0] op, input logic [7:0] off,
                        input logic [15:0] word, input bit midStart);
    logic [15:0] res;
    logic [7:0]  hiAddr;
    res    = (op == 8'h1A) ? word - 16'd1 : word + 16'd1;
    hiAddr = off + 8'd1;
    mem[off]    = word[7:0];
    mem[hiAddr] = word[15:8];
    progByte = off;
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    chk(opFetch && !busRead && !busWrite && !done, "R3 fetch cycle",
        {opFetch, busRead, busWrite}, 3'b100);
    @(negedge clk);
    chk(busRead && !busWrite && busAddr == off, "R3 low read", busAddr, off);
    if (midStart) begin start = 1'b1; opcode = 8'h3A; end
    @(negedge clk);
    start = 1'b0;
    chk(busWrite && busAddr == off && busWdata == res[7:0], "R2 low write",
        busWdata, res[7:0]);
    @(negedge clk);
    chk(busRead && !busWrite && busAddr == hiAddr,
        (off == 8'hFF) ? "R7 high read wrap" : "R4 high read after low write",
        busAddr, hiAddr);
    @(negedge clk);
    chk(busWrite && done && busAddr == hiAddr && busWdata == res[15:8],
        "R5 high write with carry", busWdata, res[15:8]);
    chk(flagN == res[15], (res == 16'hFFFF) ? "R9 N on wrap" : "R6 N flag", flagN, res[15]);
    chk(flagZ == (res == 16'h0000), (res == 16'h0000) ? "R9 Z on wrap" : "R6 Z flag",
        flagZ, res == 16'h0000);
    @(negedge clk);
    chk(!done && !opFetch && !busRead && !busWrite, "R8 single done, mid start ignored",
        {done, opFetch, busRead, busWrite}, 0);
    chk({mem[hiAddr], mem[off]} == res, "R2 memory word", {mem[hiAddr], mem[off]}, res);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!opFetch && !busRead && !busWrite && !done, "R1 reset idle",
        {opFetch, busRead, busWrite, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!opFetch && !busRead && !busWrite && !done, "R1 idle after reset",
        {opFetch, busRead, busWrite, done}, 0);

    // Unrecognised opcodes are ignored (R2)
    for (int k = 0; k < 4; k++) begin
      start = 1'b1;
      opcode = (k == 0) ? 8'h3B : (k == 1) ? 8'h1B : (k == 2) ? 8'hAB : 8'h00;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk(!opFetch && !busRead && !busWrite && !done, "R2 other opcode ignored",
          {opFetch, busRead, busWrite, done}, 0);
    end

    runOne(8'h3A, 8'h40, 16'hFFFF, 1'b0);   // R9
    runOne(8'h1A, 8'h40, 16'h0000, 1'b0);   // R9
    runOne(8'h3A, 8'hFF, 16'h12FF, 1'b1);   // R7 wrap, R8 mid start

    for (int hiSel = 0; hiSel < 4; hiSel++) begin
      for (int lo = 0; lo < 256; lo++) begin
        for (int d = 0; d < 2; d++) begin
          logic [7:0] hi;
          logic [7:0] off;
          hi  = (hiSel == 0) ? 8'h00 : (hiSel == 1) ? 8'h7F : (hiSel == 2) ? 8'h80 : 8'hFF;
          off = (lo % 3 == 0) ? 8'hFF : (lo % 3 == 1) ? 8'h00 : 8'h7E;
          runOne(d ? 8'h1A : 8'h3A, off, {hi, lo[7:0]}, lo[4]);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule